// File: doc/BRIEF.md
# Pitch Bend Message Encoder

This block turns a signed pitch bend request into the three bytes of a MIDI pitch bend channel message. A request carries a 4-bit channel number and a signed 16-bit bend amount. The block checks that the amount fits in the signed 14-bit span and refuses anything outside it with a one-cycle error pulse. An accepted amount is offset so that the most negative bend becomes code zero, and the 14-bit code is split into two 7-bit data bytes.

Output bytes leave on a byte-wide valid/ready stream: first the status byte, then the low seven code bits, then the high seven. A byte is taken on a rising edge where `out_valid` and `out_ready` are both high. While `out_ready` is low the block holds `out_valid` and `out_data` unchanged, so the consumer may stall it for any number of cycles. The request side uses a plain strobe with `req_ready`. A request counts only in a cycle where the encoder is idle. The channel and code are registered when the request is accepted.

Top module: `pbend_encoder`

## Requirements
- R1: Bend amounts from -8192 to +8191 inclusive are accepted and produce a message.
- R2: A request whose amount lies outside that span, made while idle, raises `err_pulse` for exactly the following cycle. It emits no byte and leaves the block idle.
- R3: The 14-bit code equals the amount plus 8192, so -8192 gives 0, 0 gives 0x2000 and +8191 gives 0x3FFF.
- R4: The second byte is {0, code[6:0]} and the third byte is {0, code[13:7]}. Bit 7 of both data bytes is always 0.
- R5: The first byte is the status byte {4'hE, channel}, with the channel in bits 3:0.
- R6: The bytes leave in the order status, low, high, one per rising edge where `out_valid` and `out_ready` are both high.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change on the next cycle.
- R8: `req_ready` is high only when idle. A request made while busy is ignored: it raises no error and does not change the message in flight.
- R9: `busy` and `out_valid` rise in the cycle after acceptance and fall in the cycle after the third byte is taken.
- R10: Changes to `req_chan` and `req_value` after acceptance do not alter the message in flight.
- R11: After reset, `busy`, `out_valid` and `err_pulse` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_chan | input | 4 | Channel number for the request |
| req_value | input | 16 | Signed bend amount, two's complement |
| req_ready | output | 1 | High when a request will be taken |
| busy | output | 1 | High from acceptance until the last byte is taken |
| err_pulse | output | 1 | One-cycle flag for a rejected request |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer takes the byte this cycle |
| out_data | output | 8 | Output byte |

## Verification
On every cycle, the embedded assertions check the stall rule on the output stream. They also check the zero top bit of data bytes, the 0xE status nibble, the return to idle after the third byte, and the link between acceptance and `busy`. They check as well that a rejected or ignored request cannot leave the encoder busy or raise an error. Only the bench scenarios show that the byte values are right for each amount. These include the range edges, just past the edges and the centre. The scenarios also show that the byte order holds under changing back-pressure and that changing the inputs during a send leaves the message unchanged.

// File: rtl/pbend_pkg.sv
package pbend_pkg;
  // Upper nibble of a pitch bend status byte
  localparam logic [3:0] PB_STATUS_NIB = 4'hE;

  typedef enum logic [1:0] {
    PB_IDLE = 2'd0,
    PB_STAT = 2'd1,
    PB_LOW  = 2'd2,
    PB_HIGH = 2'd3
  } pb_state_t;
endpackage

// File: rtl/pbend_range_check.sv
module pbend_range_check #(
  parameter int VAL_W  = 16,
  parameter int CODE_W = 14
) (
  input  logic [VAL_W-1:0]  value,
  output logic              in_range,
  output logic [CODE_W-1:0] code
);
  localparam int TOP_W = VAL_W - CODE_W + 1;

  logic [TOP_W-1:0] top_bits;

  // The amount fits the signed CODE_W span when all bits above the code's
  // sign position repeat that sign bit.
  assign top_bits = value[VAL_W-1:CODE_W-1];
  assign in_range = (&top_bits) | (~|top_bits);

  // Adding half the span flips the sign bit of the CODE_W-bit field.
  assign code = {~value[CODE_W-1], value[CODE_W-2:0]};
endmodule

// File: rtl/pbend_capture.sv
module pbend_capture #(
  parameter int CHAN_W = 4,
  parameter int CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CHAN_W-1:0] chan_in,
  input  logic [CODE_W-1:0] code_in,
  output logic [CHAN_W-1:0] chan_q,
  output logic [CODE_W-1:0] code_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_q <= '0;
      code_q <= '0;
    end else if (load) begin
      chan_q <= chan_in;
      code_q <= code_in;
    end
  end
endmodule

// File: rtl/pbend_tx_seq.sv
module pbend_tx_seq
  import pbend_pkg::*;
#(
  parameter int CHAN_W    = 4,
  parameter int DATA_BITS = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   in_range,
  input  logic [CHAN_W-1:0]      chan_q,
  input  logic [2*DATA_BITS-1:0] code_q,
  input  logic                   out_ready,
  output logic                   idle,
  output logic                   load,
  output logic                   err_pulse,
  output logic                   out_valid,
  output logic [DATA_BITS:0]     out_data
);
  localparam int BYTE_W = DATA_BITS + 1;

  pb_state_t state, state_nx;
  logic      take;

  assign idle  = (state == PB_IDLE);
  assign load  = idle && req_valid && in_range;
  assign take  = out_valid && out_ready;
  assign out_valid = !idle;

  always_comb begin
    state_nx = state;
    unique case (state)
      PB_IDLE: if (load) state_nx = PB_STAT;
      PB_STAT: if (take) state_nx = PB_LOW;
      PB_LOW:  if (take) state_nx = PB_HIGH;
      PB_HIGH: if (take) state_nx = PB_IDLE;
      default: state_nx = PB_IDLE;
    endcase
  end

  always_comb begin
    unique case (state)
      PB_STAT: out_data = BYTE_W'({PB_STATUS_NIB, chan_q});
      PB_LOW:  out_data = {1'b0, code_q[DATA_BITS-1:0]};
      PB_HIGH: out_data = {1'b0, code_q[2*DATA_BITS-1:DATA_BITS]};
      default: out_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= PB_IDLE;
      err_pulse <= 1'b0;
    end else begin
      state     <= state_nx;
      err_pulse <= idle && req_valid && !in_range;
    end
  end

  // R7
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R4
  data_msb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && state != PB_STAT) |-> (out_data[DATA_BITS] == 1'b0));

  // R5
  status_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PB_STAT) |-> (out_data[BYTE_W-1:BYTE_W-4] == PB_STATUS_NIB));

  // R9
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PB_HIGH && take) |=> !out_valid);
endmodule

// File: rtl/pbend_encoder.sv
module pbend_encoder #(
  parameter int CHAN_W    = 4,
  parameter int VAL_W     = 16,
  parameter int DATA_BITS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic [VAL_W-1:0]  req_value,
  output logic              req_ready,
  output logic              busy,
  output logic              err_pulse,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_BITS:0] out_data
);
  localparam int CODE_W = 2 * DATA_BITS;

  logic              in_range;
  logic [CODE_W-1:0] code;
  logic [CODE_W-1:0] code_q;
  logic [CHAN_W-1:0] chan_q;
  logic              idle;
  logic              load;

  pbend_range_check #(.VAL_W(VAL_W), .CODE_W(CODE_W)) u_range (
    .value    (req_value),
    .in_range (in_range),
    .code     (code)
  );

  pbend_capture #(.CHAN_W(CHAN_W), .CODE_W(CODE_W)) u_capture (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .chan_in (req_chan),
    .code_in (code),
    .chan_q  (chan_q),
    .code_q  (code_q)
  );

  pbend_tx_seq #(.CHAN_W(CHAN_W), .DATA_BITS(DATA_BITS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .in_range  (in_range),
    .chan_q    (chan_q),
    .code_q    (code_q),
    .out_ready (out_ready),
    .idle      (idle),
    .load      (load),
    .err_pulse (err_pulse),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  assign req_ready = idle;
  assign busy      = !idle;

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && in_range) |=> busy);

  // R2
  reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !busy);

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> !err_pulse);
endmodule

// File: tb/pbend_encoder_bench.sv
module pbend_encoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rv;
  logic [3:0]  ch;
  logic [15:0] val;
  int          mval;
  logic        ordy;
  logic        req_ready, busy, err_pulse, out_valid;
  logic [7:0]  out_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model state
  int mstate = 0;          // 0 idle, 1..3 = byte index + 1
  int mbytes[3];
  bit merr = 0;

  always #5 clk = ~clk;

  pbend_encoder u_pbend_encoder (
    .clk(clk), .rst_n(rst_n), .req_valid(rv), .req_chan(ch), .req_value(val),
    .req_ready(req_ready), .busy(busy), .err_pulse(err_pulse),
    .out_valid(out_valid), .out_ready(ordy), .out_data(out_data)
  );

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit was_idle;
    int code;
    was_idle = (mstate == 0);
    merr = was_idle && rv && (mval < -8192 || mval > 8191);
    if (was_idle) begin
      if (rv && !merr) begin
        code = mval + 8192;
        mbytes[0] = 8'hE0 | ch;
        mbytes[1] = code & 8'h7F;
        mbytes[2] = (code >> 7) & 8'h7F;
        mstate = 1;
      end
    end else if (ordy) begin
      mstate = (mstate == 3) ? 0 : mstate + 1;
    end
  endtask

  task automatic compare();
    check("R8 req_ready", req_ready, mstate == 0);
    check("R9 busy", busy, mstate != 0);
    check("R9 out_valid", out_valid, mstate != 0);
    check("R1/R2 err_pulse", err_pulse, merr);
    if (mstate != 0)
      check("R3/R4/R5/R6/R7/R10 out_data", out_data, mbytes[mstate-1]);
  endtask

  task automatic cyc(logic v, logic [3:0] c, int value, logic o);
    @(negedge clk);
    model_step();
    compare();
    rv = v; ch = c; mval = value; val = 16'(value); ordy = o;
  endtask

  task automatic send(logic [3:0] c, int value);
    cyc(1'b1, c, value, 1'b1);
    repeat (4) cyc(1'b0, 4'h0, 0, 1'b1);
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rv = 1'b0; ch = '0; val = '0; mval = 0; ordy = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 busy", busy, 0);
    check("R11 out_valid", out_valid, 0);
    check("R11 err_pulse", err_pulse, 0);
    check("R11 req_ready", req_ready, 1);
    rst_n = 1'b1;

    // R3 centre, R1 edges, R5 channels
    send(4'h0, 0);
    send(4'h5, -8192);
    send(4'hF, 8191);
    send(4'h9, 1);
    send(4'h3, -1);
    // R2 just past each edge and far out
    send(4'h1, 8192);
    send(4'h1, -8193);
    send(4'h2, 32767);
    send(4'h2, -32768);

    // R7 back-pressure during a message
    cyc(1'b1, 4'hA, 1234, 1'b0);
    repeat (3) cyc(1'b0, 4'h0, 0, 1'b0);
    cyc(1'b0, 4'h0, 0, 1'b1);
    cyc(1'b0, 4'h0, 0, 1'b0);
    cyc(1'b0, 4'h0, 0, 1'b1);
    cyc(1'b0, 4'h0, 0, 1'b0);
    repeat (3) cyc(1'b0, 4'h0, 0, 1'b1);

    // R8/R10 requests and input changes while busy are ignored
    cyc(1'b1, 4'h7, -4000, 1'b0);
    cyc(1'b1, 4'hC, 9000, 1'b0);
    cyc(1'b1, 4'hD, 500, 1'b1);
    cyc(1'b1, 4'hE, -20000, 1'b1);
    cyc(1'b1, 4'h1, 77, 1'b1);
    repeat (3) cyc(1'b0, 4'h0, 0, 1'b1);

    // random mix covering R1..R10
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 6)
        cyc(1'($urandom_range(0, 1)), 4'($urandom),
            $urandom_range(0, 16383) - 8192, 1'($urandom_range(0, 2) != 0));
      else if (r < 8)
        cyc(1'b1, 4'($urandom), $urandom_range(0, 1) ? 8191 : -8192,
            1'($urandom_range(0, 1)));
      else
        cyc(1'b1, 4'($urandom), $urandom_range(8192, 20000) *
            ($urandom_range(0, 1) ? 1 : -1) - 1, 1'($urandom_range(0, 1)));
    end
    repeat (6) cyc(1'b0, 4'h0, 0, 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule